// File: doc/BRIEF.md
# Serial SAR Converter Sequencer

This block sits on the host side of a 16-bit successive-approximation converter that has a serial result port. It drives the converter's sample, conversion-clock and calibrate inputs, watches the converter's busy output, and shifts in the serial result. A host asks for work with single-cycle request pulses. Each conversion holds the sample line high for a set number of system cycles, then drops it, which is the sampling instant. After a setup gap the block issues exactly seventeen clock pulses. It collects sixteen result bits on the rising edges of the converter's data clock and presents them as a signed word with a one-cycle strobe.

On a calibration request the block holds the calibrate line high while it toggles the conversion clock. It then releases the line and keeps clocking until busy falls. After that it runs one conversion whose result is thrown away. If busy stays high for too long, the block raises an error flag and returns to idle without the extra conversion. All timing is counted in system clock cycles and set by parameters. The three converter inputs (busy, data, data clock) are synchronised before use.

Top module: `sar_host_seq`

## Requirements
- R1: After reset, `ready` is 1 and `adcSample`, `adcClk`, `adcCal`, `resultValid` and `calError` are 0.
- R2: A conversion starts with `adcSample` high for exactly ACQ_CYC system cycles, during which `adcClk` stays low.
- R3: The first `adcClk` rise of a conversion comes no sooner than SETUP_CYC cycles after `adcSample` falls.
- R4: Each conversion issues exactly 17 `adcClk` pulses. Each pulse is high for CLK_HI_CYC cycles and low for at least CLK_LO_CYC cycles. No further pulses follow once busy has fallen.
- R5: `adcSample` does not change between its falling edge and the end of that conversion's busy period.
- R6: The result is built from sixteen bits, each taken at a rising edge of `adcDataClk`. The first bit is bit 15 (the sign bit) and the last is bit 0. The word appears on `result` with `resultValid` high for exactly one cycle, once per host conversion. `ready` is high in that same cycle.
- R7: A calibration holds `adcCal` high for exactly CAL_HOLD_CLKS `adcClk` pulses with `adcSample` low. After that, `adcClk` keeps pulsing with `adcCal` low until busy is seen low.
- R8: A successful calibration is followed by exactly one conversion. That conversion produces no `resultValid`.
- R9: If busy is still high after CAL_TIMEOUT_CLKS pulses with `adcCal` low, `calError` becomes 1 and `ready` returns. No conversion follows. `calError` goes back to 0 when the next calibration starts.
- R10: `startConv` and `startCal` are ignored while `ready` is 0. If both arrive together while idle, the calibration runs.
- R11: `ready` is 0 from an accepted request until its sequence ends, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startConv | input | 1 | Single-cycle conversion request |
| startCal | input | 1 | Single-cycle calibration request |
| ready | output | 1 | Idle, accepting requests |
| result | output | 16 | Signed conversion result |
| resultValid | output | 1 | One-cycle strobe for `result` |
| calError | output | 1 | Busy did not fall within the calibration limit |
| adcSample | output | 1 | Converter sample line |
| adcClk | output | 1 | Converter conversion clock |
| adcCal | output | 1 | Converter calibrate line |
| adcBusy | input | 1 | Converter busy flag |
| adcData | input | 1 | Converter serial data |
| adcDataClk | input | 1 | Converter serial data clock |

## Verification
A sequencer stuck in the wrong state shows up at the ports within one pulse period. It appears as an eighteenth clock, a sample edge during busy, or `ready` that never returns, and the behavioural converter in the bench reports each of these on the cycle it happens. A wrong bit count or a wrong shift order does not show until the end of the conversion. There the word on `result` differs from the value the converter was given, so test words include both sign extremes, zero, all ones and mixed patterns. Calibration faults show as a wrong hold-pulse count, a missing or extra dummy conversion, a stray strobe, or an error flag that stays set.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

  localparam int TIMER_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CALH_HI,
    ST_CALH_LO,
    ST_CALW_HI,
    ST_CALW_LO,
    ST_ACQ,
    ST_SETUP,
    ST_CONV_HI,
    ST_CONV_LO,
    ST_FINISH
  } seqState_t;

  typedef struct packed {
    logic               tmrLoad;
    logic [TIMER_W-1:0] tmrVal;
    logic               pulseClr;
    logic               pulseInc;
    logic               shiftClr;
    logic               publish;
    logic               errSet;
    logic               errClr;
    logic               sampleLvl;
    logic               clkLvl;
    logic               calLvl;
  } seqCmd_t;

endpackage

// File: rtl/sar_host_ctl.sv
module sar_host_ctl
  import sar_host_pkg::*;
#(
  parameter int ACQ_CYC          = 8,
  parameter int SETUP_CYC        = 2,
  parameter int CLK_HI_CYC       = 2,
  parameter int CLK_LO_CYC       = 2,
  parameter int CAL_HOLD_CLKS    = 4,
  parameter int CAL_TIMEOUT_CLKS = 5000,
  parameter int CONV_CLKS        = 17,
  parameter int CNT_W            = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startConv,
  input  logic             startCal,
  input  logic             tmrZero,
  input  logic [CNT_W-1:0] pulseCnt,
  input  logic             bitsDone,
  input  logic             busySync,
  output seqCmd_t          cmd,
  output logic             ready
);

  seqState_t st, nxt;
  logic dummy, dummyNxt;

  function automatic logic [TIMER_W-1:0] durOf(seqState_t s);
    case (s)
      ST_ACQ:                              durOf = TIMER_W'(ACQ_CYC - 1);
      ST_SETUP:                            durOf = TIMER_W'(SETUP_CYC - 1);
      ST_CALH_HI, ST_CALW_HI, ST_CONV_HI:  durOf = TIMER_W'(CLK_HI_CYC - 1);
      ST_CALH_LO, ST_CALW_LO, ST_CONV_LO:  durOf = TIMER_W'(CLK_LO_CYC - 1);
      default:                             durOf = '0;
    endcase
  endfunction

  function automatic logic isHigh(seqState_t s);
    isHigh = (s == ST_CALH_HI) || (s == ST_CALW_HI) || (s == ST_CONV_HI);
  endfunction

  always_comb begin
    nxt      = st;
    dummyNxt = dummy;
    cmd      = '0;
    case (st)
      ST_IDLE: begin
        if (startCal) begin
          nxt          = ST_CALH_HI;
          cmd.errClr   = 1'b1;
          cmd.pulseClr = 1'b1;
        end else if (startConv) begin
          nxt      = ST_ACQ;
          dummyNxt = 1'b0;
        end
      end
      ST_CALH_HI: if (tmrZero) nxt = ST_CALH_LO;
      ST_CALH_LO: begin
        if (tmrZero) begin
          if (pulseCnt >= CNT_W'(CAL_HOLD_CLKS)) begin
            nxt          = ST_CALW_HI;
            cmd.pulseClr = 1'b1;
          end else begin
            nxt = ST_CALH_HI;
          end
        end
      end
      ST_CALW_HI: if (tmrZero) nxt = ST_CALW_LO;
      ST_CALW_LO: begin
        if (tmrZero) begin
          if (!busySync) begin
            nxt      = ST_ACQ;
            dummyNxt = 1'b1;
          end else if (pulseCnt >= CNT_W'(CAL_TIMEOUT_CLKS)) begin
            nxt        = ST_IDLE;
            cmd.errSet = 1'b1;
          end else begin
            nxt = ST_CALW_HI;
          end
        end
      end
      ST_ACQ:     if (tmrZero) nxt = ST_SETUP;
      ST_SETUP:   if (tmrZero) nxt = ST_CONV_HI;
      ST_CONV_HI: if (tmrZero) nxt = ST_CONV_LO;
      ST_CONV_LO: begin
        if (tmrZero) begin
          if (pulseCnt >= CNT_W'(CONV_CLKS)) nxt = ST_FINISH;
          else                               nxt = ST_CONV_HI;
        end
      end
      ST_FINISH: begin
        if (bitsDone && !busySync) begin
          nxt         = ST_IDLE;
          cmd.publish = !dummy;
          dummyNxt    = 1'b0;
        end
      end
      default: nxt = ST_IDLE;
    endcase

    if (nxt != st) begin
      cmd.tmrLoad = 1'b1;
      cmd.tmrVal  = durOf(nxt);
      if (isHigh(nxt)) cmd.pulseInc = 1'b1;
      if (nxt == ST_ACQ) begin
        cmd.pulseClr = 1'b1;
        cmd.shiftClr = 1'b1;
      end
    end

    cmd.sampleLvl = (nxt == ST_ACQ);
    cmd.clkLvl    = isHigh(nxt);
    cmd.calLvl    = (nxt == ST_CALH_HI) || (nxt == ST_CALH_LO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      dummy <= 1'b0;
    end else begin
      st    <= nxt;
      dummy <= dummyNxt;
    end
  end

  assign ready = (st == ST_IDLE);

endmodule

// File: rtl/sar_host_dp.sv
module sar_host_dp
  import sar_host_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int CNT_W       = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqCmd_t                 cmd,
  input  logic                    adcBusy,
  input  logic                    adcData,
  input  logic                    adcDataClk,
  output logic                    tmrZero,
  output logic [CNT_W-1:0]        pulseCnt,
  output logic                    bitsDone,
  output logic                    busySync,
  output logic signed [WIDTH-1:0] result,
  output logic                    resultValid,
  output logic                    calError,
  output logic                    adcSample,
  output logic                    adcClk,
  output logic                    adcCal
);

  localparam int BIT_W = $clog2(WIDTH + 1);

  logic [TIMER_W-1:0]     tmrCnt;
  logic [SYNC_STAGES-1:0] busySh, dataSh, dclkSh;
  logic                   dclkPrev, dclkRise;
  logic [WIDTH-1:0]       shiftReg;
  logic [BIT_W-1:0]       bitCnt;

  // input synchronisers, one chain per converter output
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          busySh[g] <= 1'b0;
          dataSh[g] <= 1'b0;
          dclkSh[g] <= 1'b0;
        end else if (g == 0) begin
          busySh[g] <= adcBusy;
          dataSh[g] <= adcData;
          dclkSh[g] <= adcDataClk;
        end else begin
          busySh[g] <= busySh[g-1];
          dataSh[g] <= dataSh[g-1];
          dclkSh[g] <= dclkSh[g-1];
        end
      end
    end
  endgenerate

  assign busySync = busySh[SYNC_STAGES-1];
  assign dclkRise = dclkSh[SYNC_STAGES-1] & ~dclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (cmd.tmrLoad) begin
      tmrCnt <= cmd.tmrVal;
    end else if (tmrCnt != '0) begin
      tmrCnt <= tmrCnt - 1'b1;
    end
  end
  assign tmrZero = (tmrCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (cmd.pulseClr) begin
      pulseCnt <= cmd.pulseInc ? CNT_W'(1) : '0;
    end else if (cmd.pulseInc) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dclkPrev <= 1'b0;
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      dclkPrev <= dclkSh[SYNC_STAGES-1];
      if (cmd.shiftClr) begin
        shiftReg <= '0;
        bitCnt   <= '0;
      end else if (dclkRise && !bitsDone) begin
        shiftReg <= {shiftReg[WIDTH-2:0], dataSh[SYNC_STAGES-1]};
        bitCnt   <= bitCnt + 1'b1;
      end
    end
  end
  assign bitsDone = (bitCnt == BIT_W'(WIDTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
      calError    <= 1'b0;
      adcSample   <= 1'b0;
      adcClk      <= 1'b0;
      adcCal      <= 1'b0;
    end else begin
      resultValid <= cmd.publish;
      if (cmd.publish) result <= shiftReg;
      if (cmd.errClr)      calError <= 1'b0;
      else if (cmd.errSet) calError <= 1'b1;
      adcSample <= cmd.sampleLvl;
      adcClk    <= cmd.clkLvl;
      adcCal    <= cmd.calLvl;
    end
  end

endmodule

// File: rtl/sar_host_seq.sv
module sar_host_seq
  import sar_host_pkg::*;
#(
  parameter int WIDTH            = 16,
  parameter int ACQ_CYC          = 8,
  parameter int SETUP_CYC        = 2,
  parameter int CLK_HI_CYC       = 2,
  parameter int CLK_LO_CYC       = 2,
  parameter int CAL_HOLD_CLKS    = 4,
  parameter int CAL_TIMEOUT_CLKS = 5000,
  parameter int SYNC_STAGES      = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startConv,
  input  logic                    startCal,
  output logic                    ready,
  output logic signed [WIDTH-1:0] result,
  output logic                    resultValid,
  output logic                    calError,
  output logic                    adcSample,
  output logic                    adcClk,
  output logic                    adcCal,
  input  logic                    adcBusy,
  input  logic                    adcData,
  input  logic                    adcDataClk
);

  localparam int CONV_CLKS = WIDTH + 1;
  localparam int MAX_A     = (CAL_TIMEOUT_CLKS > CONV_CLKS) ? CAL_TIMEOUT_CLKS : CONV_CLKS;
  localparam int CNT_MAX   = (MAX_A > CAL_HOLD_CLKS) ? MAX_A : CAL_HOLD_CLKS;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  seqCmd_t          cmd;
  logic             tmrZero, bitsDone, busySync;
  logic [CNT_W-1:0] pulseCnt;

  sar_host_ctl #(
    .ACQ_CYC(ACQ_CYC), .SETUP_CYC(SETUP_CYC), .CLK_HI_CYC(CLK_HI_CYC),
    .CLK_LO_CYC(CLK_LO_CYC), .CAL_HOLD_CLKS(CAL_HOLD_CLKS),
    .CAL_TIMEOUT_CLKS(CAL_TIMEOUT_CLKS), .CONV_CLKS(CONV_CLKS), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .startConv(startConv), .startCal(startCal),
    .tmrZero(tmrZero), .pulseCnt(pulseCnt), .bitsDone(bitsDone),
    .busySync(busySync), .cmd(cmd), .ready(ready)
  );

  sar_host_dp #(
    .WIDTH(WIDTH), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .adcBusy(adcBusy), .adcData(adcData),
    .adcDataClk(adcDataClk), .tmrZero(tmrZero), .pulseCnt(pulseCnt),
    .bitsDone(bitsDone), .busySync(busySync), .result(result),
    .resultValid(resultValid), .calError(calError), .adcSample(adcSample),
    .adcClk(adcClk), .adcCal(adcCal)
  );

endmodule

// File: rtl/sar_host_chk.sv
module sar_host_chk #(
  parameter int CLK_HI_CYC = 2
) (
  input logic clk,
  input logic rstN,
  input logic ready,
  input logic resultValid,
  input logic calError,
  input logic adcSample,
  input logic adcClk,
  input logic adcCal
);

  logic [15:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       hiCnt <= '0;
    else if (adcClk) hiCnt <= hiCnt + 1'b1;
    else             hiCnt <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (!adcSample && !adcClk && !adcCal)); // R11

  AST_NO_CLK_IN_ACQ: assert property (@(posedge clk) disable iff (!rstN)
    adcSample |-> !adcClk); // R2

  AST_CAL_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    adcCal |-> !adcSample); // R7

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R6

  AST_VALID_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ready); // R6

  AST_CLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcClk) |-> (hiCnt == 16'(CLK_HI_CYC))); // R4

  AST_ERR_AT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calError) |-> ready); // R9

endmodule

bind sar_host_seq sar_host_chk #(.CLK_HI_CYC(CLK_HI_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .ready(ready), .resultValid(resultValid),
  .calError(calError), .adcSample(adcSample), .adcClk(adcClk), .adcCal(adcCal)
);

// File: tb/sar_host_seq_tb.sv
module sar_host_seq_tb;

  localparam int ACQ   = 6;
  localparam int SETUP = 3;
  localparam int HI    = 2;
  localparam int LO    = 3;
  localparam int HOLD  = 4;
  localparam int TMO   = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startConv = 1'b0, startCal = 1'b0;
  logic ready, resultValid, calError, adcSample, adcClk, adcCal;
  logic signed [15:0] result;
  logic adcBusy = 1'b0, adcData = 1'b0, adcDataClk = 1'b0;

  always #2 clk = ~clk;

  sar_host_seq #(
    .WIDTH(16), .ACQ_CYC(ACQ), .SETUP_CYC(SETUP), .CLK_HI_CYC(HI),
    .CLK_LO_CYC(LO), .CAL_HOLD_CLKS(HOLD), .CAL_TIMEOUT_CLKS(TMO), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startConv(startConv), .startCal(startCal),
    .ready(ready), .result(result), .resultValid(resultValid), .calError(calError),
    .adcSample(adcSample), .adcClk(adcClk), .adcCal(adcCal), .adcBusy(adcBusy),
    .adcData(adcData), .adcDataClk(adcDataClk)
  );

  int errors = 0, checks = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural converter
  logic [15:0] convQ[$];
  logic [15:0] expQ[$];
  logic [15:0] word;
  logic pS = 0, pC = 0, pK = 0;
  bit   conv = 0, calMode = 0, afterConv = 0;
  int   pulseN = 0, convCount = 0, calStarts = 0;
  int   holdPulses = 0, holdSeen = 0, calPulses = 0, calLen = 30;
  int   sRise = 0, sFall = 0, hiRun = 0, loRun = 100;
  int   vAcq = 0, vSetup = 0, vPulse = 0, vSample = 0, vWidth = 0;
  int   validCnt = 0;

  always @(posedge clk) begin
    cyc++;
    if (adcClk) begin hiRun++; loRun = 0; end else begin loRun++; end
    if (adcCal && !pK) begin
      adcBusy <= 1'b1; calMode = 1; conv = 0; holdPulses = 0; calStarts++; afterConv = 0;
    end
    if (adcCal && adcClk && !pC) holdPulses++;
    if (!adcCal && pK) begin holdSeen = holdPulses; calPulses = 0; end
    if (calMode && !adcCal && adcClk && !pC) begin
      calPulses++;
      if (calPulses == calLen) begin adcBusy <= 1'b0; calMode = 0; end
    end
    if (adcSample && !pS) begin
      if (conv) vSample++;
      sRise = cyc; afterConv = 0;
    end
    if (!adcSample && pS) begin
      if (conv) vSample++;
      else if (!calMode) begin
        if (cyc - sRise != ACQ) vAcq++;
        conv = 1; pulseN = 0; convCount++;
        word = (convQ.size() > 0) ? convQ.pop_front() : 16'h5A5A;
        sFall = cyc;
      end
    end
    if (adcClk && !pC) begin
      if (conv) begin
        pulseN++;
        if (pulseN == 1) begin
          adcBusy <= 1'b1;
          if (cyc - sFall < SETUP) vSetup++;
        end
        if (pulseN >= 2 && pulseN <= 17) begin
          adcData <= word[17-pulseN]; adcDataClk <= 1'b0;
        end
        if (pulseN > 17) vPulse++;
      end else if (afterConv && !calMode) vPulse++;
    end
    if (!adcClk && pC) begin
      if (hiRun != HI) vWidth++;
      hiRun = 0;
      if (conv) begin
        if (pulseN >= 2) adcDataClk <= 1'b1;
        if (pulseN == 17) begin adcBusy <= 1'b0; conv = 0; afterConv = 1; end
      end
    end
    pS = adcSample; pC = adcClk; pK = adcCal;
  end

  // low width measured separately: a rise must follow at least LO low cycles
  int lowRun = 0;
  always @(posedge clk) begin
    if (adcClk && !pC && rstN && lowRun < LO && cyc > 2) vWidth++;
    if (adcClk) lowRun = 0; else lowRun++;
  end

  // result monitor, compared on every clock
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      validCnt++;
      if (expQ.size() == 0) check(0, "R8 unexpected resultValid", result, 0);
      else begin
        logic [15:0] e;
        e = expQ.pop_front();
        check(result == $signed(e), "R6 result word", result, $signed(e));
      end
    end
  end

  task automatic pulseReq(input bit conv_, input bit cal_);
    @(negedge clk);
    startConv = conv_; startCal = cal_;
    @(negedge clk);
    startConv = 0; startCal = 0;
  endtask

  task automatic waitReady(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (ready) return;
    end
    check(0, "R11 ready timeout", 0, 1);
  endtask

  task automatic doConv(input logic [15:0] v);
    int c0, v0;
    c0 = convCount; v0 = validCnt;
    convQ.push_back(v); expQ.push_back(v);
    pulseReq(1, 0);
    check(!ready, "R11 ready drops", ready, 0);
    waitReady(400);
    @(negedge clk);
    check(convCount == c0 + 1, "R4 one conversion", convCount, c0 + 1);
    check(validCnt == v0 + 1, "R6 one strobe", validCnt, v0 + 1);
  endtask

  initial begin
    int c0, s0, v0;
    repeat (3) @(negedge clk);
    check(ready && !adcSample && !adcClk && !adcCal && !resultValid && !calError,
          "R1 reset outputs", {ready, adcSample, adcClk, adcCal, resultValid, calError}, 6'b100000);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(ready == 1, "R1 ready after reset", ready, 1);

    // calibration with dummy conversion
    c0 = convCount; v0 = validCnt;
    convQ.push_back(16'h1234);
    pulseReq(0, 1);
    waitReady(2000);
    check(holdSeen == HOLD, "R7 cal hold pulses", holdSeen, HOLD);
    check(convCount == c0 + 1, "R8 single dummy conversion", convCount, c0 + 1);
    check(validCnt == v0, "R8 dummy discarded", validCnt, v0);
    check(calError == 0, "R9 no error on good cal", calError, 0);

    // conversions across sign and bit patterns
    doConv(16'h0000);
    doConv(16'h7FFF);
    doConv(16'h8000);
    doConv(16'hFFFF);
    doConv(16'hA5C3);
    doConv(16'h0001);
    doConv(16'h3C96);

    // requests while busy are ignored
    c0 = convCount; s0 = calStarts;
    convQ.push_back(16'h6B2D); expQ.push_back(16'h6B2D);
    pulseReq(1, 0);
    repeat (20) @(negedge clk);
    pulseReq(1, 1);
    waitReady(400);
    repeat (30) @(negedge clk);
    check(convCount == c0 + 1, "R10 conv ignored while busy", convCount, c0 + 1);
    check(calStarts == s0, "R10 cal ignored while busy", calStarts, s0);

    // simultaneous requests: calibration wins
    s0 = calStarts; v0 = validCnt;
    pulseReq(1, 1);
    waitReady(2000);
    check(calStarts == s0 + 1, "R10 cal priority", calStarts, s0 + 1);
    check(validCnt == v0, "R10 no conversion result", validCnt, v0);

    // calibration timeout
    calLen = 1000000; c0 = convCount;
    pulseReq(0, 1);
    waitReady(40000);
    check(calError == 1, "R9 timeout flag", calError, 1);
    check(calPulses == TMO, "R9 pulses before timeout", calPulses, TMO);
    check(convCount == c0, "R9 no dummy after timeout", convCount, c0);

    // recovery clears the flag
    calLen = 20;
    pulseReq(0, 1);
    repeat (2) @(negedge clk);
    check(calError == 0, "R9 flag cleared on new cal", calError, 0);
    waitReady(2000);
    doConv(16'hC001);

    check(vAcq == 0, "R2 acquisition length", vAcq, 0);
    check(vSetup == 0, "R3 setup gap", vSetup, 0);
    check(vPulse == 0, "R4 pulse count", vPulse, 0);
    check(vWidth == 0, "R4 pulse widths", vWidth, 0);
    check(vSample == 0, "R5 sample quiet in conversion", vSample, 0);
    check(expQ.size() == 0, "R6 all results seen", expQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule